// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Output Latch

This block is the logic core of an eight-channel serial-controlled output switch. A host sends a bit stream on a data line, framed by a serial clock. The stream fills a shift register. A strobe then copies the shift register into a holding register, and the holding register drives one on/off enable per channel. All inputs are sampled by a fast system clock. An edge on the serial clock or on the strobe takes effect at the first system clock edge that sees the new level.

Several devices can share one serial clock and one strobe. Each device passes its most significant shift bit to the next device through a cascade output. That output changes only when the serial clock falls, so the downstream device has half a serial period of setup margin before the next rising edge.

Two inputs blank every enable without touching the stored data: a shutdown input, which can carry a PWM waveform for common dimming, and an over-temperature flag. Shutdown takes priority, and the flag is ignored while shutdown is high.

Top module: `serial_out_latch`

## Requirements
- R1: On each rising edge of `sclk_i`, the shift register takes `sdata_i` into bit 0 and every other bit moves up one place.
- R2: A frame is WIDTH bits sent most significant first: after eight rising edges and a strobe, the first bit sent drives `en_o[7]` and the last bit sent drives `en_o[0]`.
- R3: A rising edge of `strobe_i` copies the shift register into the holding register, and `en_o` shows it after that same system clock edge. At all other times the holding register keeps its value, including while new bits are shifted in.
- R4: A holding register bit of 1 switches its channel on (`en_o` bit 1), and a bit of 0 switches it off.
- R5: While `rst_n` is low at a rising `clk` edge, the shift register, the holding register and the cascade output are cleared, so `en_o` and `cas_o` read 0.
- R6: While `shutdown_i` is high, `en_o` is all zeros whatever the register contents, so a PWM waveform on `shutdown_i` dims every channel together.
- R7: While `over_temp_i` is high and `shutdown_i` is low, `en_o` is all zeros, and it returns to normal when the flag clears. While `shutdown_i` is high the flag has no effect.
- R8: Shutdown and over-temperature blank only the enables: when both are low again, `en_o` shows the unchanged holding register.
- R9: With two devices chained through `cas_o` on a shared serial clock and strobe, sixteen serial clock pulses and one strobe load both. The first eight bits sent become the downstream device's enables.
- R10: `cas_o` presents the most significant shift register bit and changes only on a falling edge of `sclk_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every other input |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data, most significant bit first |
| strobe_i | input | 1 | Copies the shift register to the holding register on its rising edge |
| shutdown_i | input | 1 | High forces all enables off; may carry PWM |
| over_temp_i | input | 1 | Over-temperature flag; high forces all enables off unless shutdown is high |
| en_o | output | WIDTH | Channel enables, 1 = on |
| cas_o | output | 1 | Cascade data to the next device in the chain |

## Verification
The bench builds two instances with the default WIDTH of 8. The first instance's `cas_o` feeds the second instance's data input, and both share the serial clock, strobe, shutdown and flag. This makes a sixteen-bit chain available, so the split of a stream between the two devices can be checked, along with the half-period offset of the cascade bit. The same instances also cover bit ordering, hold-without-strobe, blanking priority and preservation of the stored data across blanking and PWM.

// File: rtl/spl_pkg.sv
// Package: shared types for the serial output latch.
// Assumes a single system clock samples all control inputs.
package spl_pkg;
    // Edge pulses extracted from a sampled level
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/spl_edge.sv
// Module: level-to-edge converter.
// Registers one input level and flags the cycle in which it rises or falls.
// Assumes the input is already synchronous to clk.
module spl_edge
    import spl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sig_i,
    output edge_t edge_o
);
    logic prev_q;

    // Remember the previous sample of the input level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    assign edge_o.rise = sig_i & ~prev_q;
    assign edge_o.fall = ~sig_i & prev_q;
endmodule

// File: rtl/spl_shift.sv
// Module: serial shift register with a cascade output.
// Shifts serial data in at bit 0 on each serial clock rise. The cascade flop
// copies the top bit on each serial clock fall.
// Assumes edge pulses come from spl_edge.
module spl_shift
    import spl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  edge_t            sclk_e,
    input  logic             sdata_i,
    output logic [WIDTH-1:0] sr_o,
    output logic             cas_o
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] sr_q;
    logic             cas_q;

    // Shift in one bit per serial clock rise
    always_ff @(posedge clk) begin
        if (!rst_n)           sr_q <= '0;
        else if (sclk_e.rise) sr_q <= {sr_q[TOP-1:0], sdata_i};
    end

    // Present the top bit downstream on serial clock fall
    always_ff @(posedge clk) begin
        if (!rst_n)           cas_q <= 1'b0;
        else if (sclk_e.fall) cas_q <= sr_q[TOP];
    end

    assign sr_o  = sr_q;
    assign cas_o = cas_q;

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_e.rise |=> sr_q[0] == $past(sdata_i));

    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_e.rise |=> sr_q[TOP:1] == $past(sr_q[TOP-1:0]));

    // R10
    cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_e.fall |=> $stable(cas_q));

    // R5
    shift_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (sr_q == '0) && !cas_q);
endmodule

// File: rtl/spl_hold.sv
// Module: holding register and output blanking.
// Loads the shift register on strobe rise. Each enable is the held bit gated by
// shutdown and by the thermal flag; shutdown masks the thermal flag.
// Assumes strobe edge pulses come from spl_edge.
module spl_hold
    import spl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  edge_t            stb_e,
    input  logic [WIDTH-1:0] sr_i,
    input  logic             shutdown_i,
    input  logic             over_temp_i,
    output logic [WIDTH-1:0] en_o
);
    logic [WIDTH-1:0] held_q;
    logic             thermal_cut;
    logic             blank;

    // Capture the shift register on strobe rise
    always_ff @(posedge clk) begin
        if (!rst_n)          held_q <= '0;
        else if (stb_e.rise) held_q <= sr_i;
    end

    // Thermal cutoff only acts while shutdown is low
    always_comb begin
        thermal_cut = over_temp_i & ~shutdown_i;
        blank       = shutdown_i | thermal_cut;
    end

    // Gate each channel enable
    for (genvar g = 0; g < WIDTH; g++) begin : g_chan
        assign en_o[g] = held_q[g] & ~blank;
    end

    // R3
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_e.rise |=> held_q == $past(sr_i));

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_e.rise || stb_e.fall) |=> $stable(held_q));

    // R5
    hold_reset_chk: assert property (@(posedge clk)
        !rst_n |=> held_q == '0);
endmodule

// File: rtl/serial_out_latch.sv
// Module: cascadable serial-to-parallel output latch (top).
// Turns the serial clock and strobe into edge pulses, then feeds the shift
// register and the holding/blanking stage.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module serial_out_latch
    import spl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdata_i,
    input  logic             strobe_i,
    input  logic             shutdown_i,
    input  logic             over_temp_i,
    output logic [WIDTH-1:0] en_o,
    output logic             cas_o
);
    edge_t            sclk_e;
    edge_t            stb_e;
    logic [WIDTH-1:0] sr_w;

    spl_edge u_sclk_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sclk_i),
        .edge_o (sclk_e)
    );

    spl_edge u_stb_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (strobe_i),
        .edge_o (stb_e)
    );

    spl_shift #(.WIDTH(WIDTH)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_e  (sclk_e),
        .sdata_i (sdata_i),
        .sr_o    (sr_w),
        .cas_o   (cas_o)
    );

    spl_hold #(.WIDTH(WIDTH)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_e       (stb_e),
        .sr_i        (sr_w),
        .shutdown_i  (shutdown_i),
        .over_temp_i (over_temp_i),
        .en_o        (en_o)
    );

    // R10
    cas_tracks_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_e.fall |=> cas_o == $past(sr_w[WIDTH-1]));
endmodule

// File: tb/serial_out_latch_tb.sv
module serial_out_latch_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic strobe = 1'b0;
    logic sd = 1'b0;
    logic ot = 1'b0;
    logic [W-1:0] en_a;
    logic [W-1:0] en_b;
    logic cas_a;
    logic cas_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;  // 0: en_a, 1: en_b, 2: cas_a
        logic [7:0]  val;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    serial_out_latch #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata),
        .strobe_i(strobe), .shutdown_i(sd), .over_temp_i(ot),
        .en_o(en_a), .cas_o(cas_a)
    );

    serial_out_latch #(.WIDTH(W)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(cas_a),
        .strobe_i(strobe), .shutdown_i(sd), .over_temp_i(ot),
        .en_o(en_b), .cas_o(cas_b)
    );

    // Monitor: pop expected items and compare away from the rising edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            act = (it.kind == 0) ? en_a : (it.kind == 1) ? en_b : {7'b0, cas_a};
            checks++;
            if (act !== it.val) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic expect_item(input int kind, input logic [7:0] val, input string tag);
        item_t it;
        it.kind = kind;
        it.val  = val;
        it.tag  = tag;
        sb_q.push_back(it);
        tick();
    endtask

    task automatic send_bit(input logic b);
        sdata = b;
        sclk = 1'b1;
        tick();
        sclk = 1'b0;
        tick();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic do_latch();
        strobe = 1'b1;
        tick();
        strobe = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        // R5: reset state
        expect_item(0, 8'h00, "R5 reset en_a");
        expect_item(1, 8'h00, "R5 reset en_b");
        expect_item(2, 8'h00, "R5 reset cas");

        // R1 R2 R4: one frame, first bit to channel 7
        send_byte(8'hA5);
        expect_item(0, 8'h00, "R3 no strobe yet");
        do_latch();
        expect_item(0, 8'hA5, "R2 R4 frame A5");

        // R3: shifting without strobe keeps outputs
        send_byte(8'h3C);
        expect_item(0, 8'hA5, "R3 hold during shift");
        do_latch();
        expect_item(0, 8'h3C, "R1 R3 frame 3C");

        // R6 R8: shutdown and PWM
        for (int k = 0; k < 3; k++) begin
            sd = 1'b1;
            expect_item(0, 8'h00, "R6 shutdown blanks");
            sd = 1'b0;
            expect_item(0, 8'h3C, "R8 restore after shutdown");
        end

        // R7 R8: thermal flag
        ot = 1'b1;
        expect_item(0, 8'h00, "R7 thermal blanks");
        ot = 1'b0;
        expect_item(0, 8'h3C, "R7 R8 resume after thermal");

        // R7: flag ignored while shutdown high
        sd = 1'b1;
        ot = 1'b1;
        expect_item(0, 8'h00, "R7 both high");
        ot = 1'b0;
        expect_item(0, 8'h00, "R6 still shut");
        ot = 1'b1;
        expect_item(0, 8'h00, "R7 flag under shutdown");
        ot = 1'b0;
        sd = 1'b0;
        expect_item(0, 8'h3C, "R8 contents kept");

        // R5: reset mid-operation clears both registers
        do_reset();
        expect_item(0, 8'h00, "R5 en cleared");
        expect_item(2, 8'h00, "R5 cas cleared");
        do_latch();
        expect_item(0, 8'h00, "R5 shift register cleared");

        // R9: two-device chain, sixteen pulses
        send_byte(8'h81);
        send_byte(8'h5A);
        do_latch();
        expect_item(0, 8'h5A, "R9 upstream gets last byte");
        expect_item(1, 8'h81, "R9 downstream gets first byte");

        // R10: cascade bit changes only on serial clock fall
        do_reset();
        send_byte(8'h80);
        expect_item(2, 8'h01, "R10 cas shows top bit");
        sdata = 1'b0;
        sclk = 1'b1;
        tick();
        expect_item(2, 8'h01, "R10 cas held while sclk high");
        sclk = 1'b0;
        tick();
        expect_item(2, 8'h00, "R10 cas updated on fall");

        tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule